// File: doc/BRIEF.md
# Host/User Execution Control Arbiter

This block sequences batch execution between a host-side command path and an accelerator's user logic. It owns a single piece of state that decides who may touch the shared input buffer, output buffer and parameter registers: the host after reset, the user logic while a job runs, and nobody while an aborted job is being reset. The host issues one command at a time (run, abort, or a buffer/register access request). The arbiter grants or refuses each command with a one-cycle strobe, and a refusal is always retryable.

A run command raises a run flag towards the user logic and passes ownership to it. The user logic finishes by pulsing a clear input. Ownership then comes back to the host and a sticky done status is set for the host to poll. An abort drops the run flag at once and holds the user logic in reset for a fixed number of cycles before the host regains ownership. The host is responsible for timing out a job that never finishes.

Top module: `exec_ctrl_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `host_owns`=1, `user_run`=0, `user_rst`=0, `done`=0, `host_cmd_accept`=0 and `host_cmd_retry`=0.
- R2: A run command (op code 1) with valid high, issued while the host owns the resources, gives `user_run`=1, `host_owns`=0 and a `host_cmd_accept` pulse in the cycle after the edge.
- R3: A `user_run_clear` pulse during a job with no abort at that edge gives `user_run`=0, `host_owns`=1 and `done`=1 in the next cycle. At any other time `user_run_clear` has no effect.
- R4: An abort command (op code 2) during a job is accepted. In the next cycle `user_run` falls and `user_rst` rises. `user_rst` stays high for exactly ABORT_HOLD cycles with `host_owns`=0, and then `host_owns` returns to 1. Abort wins over a `user_run_clear` at the same edge, and `done` stays 0.
- R5: An access command (op code 3) is accepted while the host owns the resources. During a job or an abort hold it is refused with `host_cmd_retry` and changes nothing.
- R6: A run command during a job or an abort hold is refused with `host_cmd_retry` and leaves `user_run`, `user_rst` and the hold length unchanged.
- R7: An abort command while the host owns the resources is accepted and starts the same ABORT_HOLD reset window. An abort during a hold is refused.
- R8: A command with valid low, or with op code 0 (no operation), produces neither strobe and changes no state.
- R9: `done` stays set through host accesses and idle cycles, and is cleared by the next accepted run command.
- R10: Each command's strobe appears in the single cycle after its edge, and `host_cmd_accept` and `host_cmd_retry` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_cmd_valid | input | 1 | A host command is presented this cycle |
| host_cmd_op | input | 2 | Command code: 0 none, 1 run, 2 abort, 3 access |
| host_cmd_accept | output | 1 | One-cycle strobe: previous command granted |
| host_cmd_retry | output | 1 | One-cycle strobe: previous command refused, retry later |
| user_run_clear | input | 1 | Completion pulse from the user logic |
| user_run | output | 1 | Run flag to the user logic; user owns the resources |
| user_rst | output | 1 | Reset to the user logic during an abort hold |
| host_owns | output | 1 | Host holds exclusive access to buffers and registers |
| done | output | 1 | Sticky completion status for host polling |

## Verification
The bench builds the arbiter with ABORT_HOLD set to 3. This keeps the reset window short enough for commands and completion pulses to land in its first, middle and last cycle, while leaving it long enough that an off-by-one in the hold counter changes the observed length. A behavioural model tracks ownership, the hold window and the done flag, and is compared with every output on every clock. The stimulus also drives the colliding cases: clear together with abort, clear together with run, and reset in the middle of a job.

// File: rtl/exec_ctrl_pkg.sv
// Shared types for the execution control arbiter.
// Assumes: the host command code is two bits wide.
package exec_ctrl_pkg;

    typedef enum logic [1:0] {
        OP_NOP    = 2'd0,
        OP_RUN    = 2'd1,
        OP_ABORT  = 2'd2,
        OP_ACCESS = 2'd3
    } host_op_e;

    typedef enum logic [1:0] {
        ST_HOST  = 2'd0,
        ST_USER  = 2'd1,
        ST_ABORT = 2'd2
    } exec_state_e;

    typedef struct packed {
        logic grant;
        logic refuse;
        logic go_run;
        logic go_abort;
    } verdict_t;

endpackage

// File: rtl/exec_cmd_judge.sv
// Classifies the current host command against the ownership state.
// Purely combinational; assumes at most one command per cycle.
module exec_cmd_judge
    import exec_ctrl_pkg::*;
(
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  exec_state_e state,
    output verdict_t    verdict
);

    host_op_e op;
    assign op = host_op_e'(cmd_op);

    // Decide grant or refusal and which transition the command asks for.
    always_comb begin
        verdict = '0;
        if (cmd_valid && op != OP_NOP) begin
            unique case (state)
                ST_HOST: begin
                    verdict.grant    = 1'b1;
                    verdict.go_run   = (op == OP_RUN);
                    verdict.go_abort = (op == OP_ABORT);
                end
                ST_USER: begin
                    if (op == OP_ABORT) begin
                        verdict.grant    = 1'b1;
                        verdict.go_abort = 1'b1;
                    end else begin
                        verdict.refuse = 1'b1;
                    end
                end
                default: verdict.refuse = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/exec_seq_fsm.sv
// Ownership sequencer: host -> user on run, back on clear, via a timed
// reset hold on abort. Also keeps the sticky done flag.
// Assumes HOLD >= 1 and a verdict already resolved for the current state.
module exec_seq_fsm
    import exec_ctrl_pkg::*;
#(
    parameter int HOLD = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  verdict_t    verdict,
    input  logic        run_clear,
    output exec_state_e state,
    output logic        done
);

    localparam int CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD - 1);

    logic [CNT_W-1:0] hold_cnt;

    // State and hold counter progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HOST;
            hold_cnt <= '0;
        end else begin
            unique case (state)
                ST_HOST: begin
                    if (verdict.go_run) begin
                        state <= ST_USER;
                    end else if (verdict.go_abort) begin
                        state    <= ST_ABORT;
                        hold_cnt <= '0;
                    end
                end
                ST_USER: begin
                    if (verdict.go_abort) begin
                        state    <= ST_ABORT;
                        hold_cnt <= '0;
                    end else if (run_clear) begin
                        state <= ST_HOST;
                    end
                end
                default: begin
                    if (hold_cnt == CNT_LAST) begin
                        state    <= ST_HOST;
                        hold_cnt <= '0;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Sticky completion flag: set on clean finish, cleared by a new run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (verdict.go_run) begin
            done <= 1'b0;
        end else if (state == ST_USER && run_clear && !verdict.go_abort) begin
            done <= 1'b1;
        end
    end

    // R4
    hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= CNT_LAST);

    // R9
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict.go_run |=> !done);

    // R4
    abort_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict.go_abort |=> (state == ST_ABORT) && (hold_cnt == '0));

endmodule

// File: rtl/exec_resp_reg.sv
// Registers the grant/refuse verdict into one-cycle host strobes.
// Assumes the verdict never carries grant and refuse together.
module exec_resp_reg
    import exec_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  verdict_t verdict,
    output logic     accept,
    output logic     retry
);

    // Capture this cycle's decision as next cycle's strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept <= 1'b0;
            retry  <= 1'b0;
        end else begin
            accept <= verdict.grant;
            retry  <= verdict.refuse;
        end
    end

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && retry));

endmodule

// File: rtl/exec_ctrl_arbiter.sv
// Top of the execution control arbiter. Judges host commands, sequences
// ownership and decodes the state into run, reset and ownership outputs.
// Assumes one host command per cycle and a one-cycle clear pulse.
module exec_ctrl_arbiter
    import exec_ctrl_pkg::*;
#(
    parameter int ABORT_HOLD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_cmd_valid,
    input  logic [1:0] host_cmd_op,
    output logic       host_cmd_accept,
    output logic       host_cmd_retry,
    input  logic       user_run_clear,
    output logic       user_run,
    output logic       user_rst,
    output logic       host_owns,
    output logic       done
);

    exec_state_e state;
    verdict_t    verdict;

    exec_cmd_judge u_judge (
        .cmd_valid (host_cmd_valid),
        .cmd_op    (host_cmd_op),
        .state     (state),
        .verdict   (verdict)
    );

    exec_seq_fsm #(.HOLD(ABORT_HOLD)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .verdict   (verdict),
        .run_clear (user_run_clear),
        .state     (state),
        .done      (done)
    );

    exec_resp_reg u_resp (
        .clk    (clk),
        .rst_n  (rst_n),
        .verdict(verdict),
        .accept (host_cmd_accept),
        .retry  (host_cmd_retry)
    );

    // Decode ownership outputs from the sequencer state.
    always_comb begin
        user_run  = (state == ST_USER);
        user_rst  = (state == ST_ABORT);
        host_owns = (state == ST_HOST);
    end

    // R2
    run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_owns && host_cmd_valid && host_cmd_op == OP_RUN)
        |=> (user_run && !host_owns && host_cmd_accept));

    // R3
    clear_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (user_run && user_run_clear && !(host_cmd_valid && host_cmd_op == OP_ABORT))
        |=> (host_owns && done && !user_run));

    // R4
    abort_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (user_run && host_cmd_valid && host_cmd_op == OP_ABORT)
        |=> (user_rst && !user_run && !host_owns && !done && host_cmd_accept));

    // R5
    access_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_owns && host_cmd_valid && host_cmd_op == OP_ACCESS)
        |=> (host_cmd_retry && !host_cmd_accept));

    // R6
    rerun_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (user_run && !user_run_clear && host_cmd_valid && host_cmd_op == OP_RUN)
        |=> (host_cmd_retry && user_run));

    // R8
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_cmd_valid && host_cmd_op != OP_NOP)
        |=> (!host_cmd_accept && !host_cmd_retry));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(host_cmd_valid && host_cmd_op == OP_RUN)) |=> done);

    // R1
    own_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_owns, user_run, user_rst}));

endmodule

// File: tb/tb_exec_ctrl_arbiter.sv
// Bench: behavioural model compared with every output on every clock,
// plus directed checks on the corner cases.
module tb_exec_ctrl_arbiter;

    localparam int HOLD = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_v = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic       clr = 1'b0;
    logic       acc, ret, urun, urst, hown, dn;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    string cur_req = "R1";

    // model state: 0 host, 1 user, 2 abort hold
    int m_st = 0;
    int m_cnt = 0;
    int m_done = 0;
    int m_acc = 0;
    int m_ret = 0;

    exec_ctrl_arbiter #(.ABORT_HOLD(HOLD)) dut (
        .clk(clk), .rst_n(rst_n),
        .host_cmd_valid(cmd_v), .host_cmd_op(cmd_op),
        .host_cmd_accept(acc), .host_cmd_retry(ret),
        .user_run_clear(clr), .user_run(urun), .user_rst(urst),
        .host_owns(hown), .done(dn)
    );

    always #4 clk = ~clk;

    // Behavioural reference: what each edge should do given the inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_done = 0; m_acc = 0; m_ret = 0;
        end else begin
            bit is_cmd;
            is_cmd = cmd_v && cmd_op != 2'd0;
            m_acc = 0; m_ret = 0;
            if (m_st == 0) begin
                if (is_cmd) m_acc = 1;
                if (cmd_v && cmd_op == 2'd1) begin m_st = 1; m_done = 0; end
                else if (cmd_v && cmd_op == 2'd2) begin m_st = 2; m_cnt = 0; end
            end else if (m_st == 1) begin
                if (cmd_v && cmd_op == 2'd2) begin
                    m_acc = 1; m_st = 2; m_cnt = 0;
                end else begin
                    if (is_cmd) m_ret = 1;
                    if (clr) begin m_st = 0; m_done = 1; end
                end
            end else begin
                if (is_cmd) m_ret = 1;
                if (m_cnt == HOLD - 1) begin m_st = 0; m_cnt = 0; end
                else m_cnt++;
            end
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(cur_req, "user_run", urun, m_st == 1);
        chk(cur_req, "user_rst", urst, m_st == 2);
        chk(cur_req, "host_owns", hown, m_st == 0);
        chk(cur_req, "done", dn, m_done);
        chk(cur_req, "accept", acc, m_acc);
        chk(cur_req, "retry", ret, m_ret);
    endtask

    // One clock: drive at the falling edge, compare after the next one.
    task automatic tick(bit v, bit [1:0] op, bit c);
        cmd_v = v; cmd_op = op; clr = c;
        @(posedge clk);
        @(negedge clk);
        cmd_v = 1'b0; cmd_op = 2'd0; clr = 1'b0;
        compare_all();
    endtask

    initial begin
        @(negedge clk);
        cur_req = "R1";
        tick(1, 2'd1, 1);
        tick(0, 2'd0, 0);
        rst_n = 1'b1;
        chk("R1", "reset host_owns", hown, 1);
        chk("R1", "reset done", dn, 0);

        cur_req = "R5";
        tick(1, 2'd3, 0);
        chk("R5", "access granted in idle", acc, 1);
        cur_req = "R8";
        tick(1, 2'd0, 0);
        chk("R8", "nop no strobe", acc | ret, 0);
        tick(0, 2'd1, 1);
        chk("R8", "valid low ignored", hown, 1);

        cur_req = "R2";
        tick(1, 2'd1, 0);
        chk("R2", "run raises user_run", urun, 1);
        cur_req = "R5";
        tick(1, 2'd3, 0);
        chk("R5", "access refused in job", ret, 1);
        cur_req = "R6";
        tick(1, 2'd1, 0);
        chk("R6", "rerun refused", ret, 1);
        tick(0, 2'd0, 0);
        cur_req = "R3";
        tick(0, 2'd0, 1);
        chk("R3", "clear sets done", dn, 1);
        chk("R3", "clear returns host", hown, 1);
        tick(0, 2'd0, 1);
        chk("R3", "stray clear ignored", hown, 1);
        cur_req = "R9";
        tick(1, 2'd3, 0);
        tick(0, 2'd0, 0);
        chk("R9", "done held through access", dn, 1);
        tick(1, 2'd1, 0);
        chk("R9", "run clears done", dn, 0);

        cur_req = "R4";
        tick(1, 2'd2, 0);
        chk("R4", "abort raises reset", urst, 1);
        begin
            int len = 1;
            cur_req = "R6";
            tick(1, 2'd1, 0);
            if (urst) len++;
            cur_req = "R7";
            tick(1, 2'd2, 1);
            if (urst) len++;
            cur_req = "R5";
            tick(1, 2'd3, 0);
            if (urst) len++;
            for (int i = 0; i < 8 && urst; i++) begin tick(0, 2'd0, 0); len++; end
            chk("R4", "reset hold length", len, HOLD);
            chk("R4", "done stays low", dn, 0);
        end

        cur_req = "R7";
        tick(1, 2'd2, 0);
        chk("R7", "idle abort accepted", acc, 1);
        for (int i = 0; i < HOLD; i++) tick(0, 2'd0, 0);
        chk("R7", "host back after hold", hown, 1);

        cur_req = "R4";
        tick(1, 2'd1, 0);
        tick(1, 2'd2, 1);
        chk("R4", "abort beats clear", urst, 1);
        for (int i = 0; i < HOLD; i++) tick(0, 2'd0, 0);

        cur_req = "R6";
        tick(1, 2'd1, 0);
        tick(1, 2'd1, 1);
        chk("R6", "rerun with clear retried", ret, 1);
        chk("R3", "clear still completes", dn, 1);

        cur_req = "R10";
        tick(1, 2'd1, 0);
        chk("R10", "single strobe", acc + ret, 1);
        tick(0, 2'd0, 0);
        chk("R10", "strobe lasts one cycle", acc + ret, 0);

        cur_req = "R1";
        rst_n = 1'b0;
        tick(0, 2'd0, 0);
        rst_n = 1'b1;
        chk("R1", "reset mid-job", hown, 1);
        tick(0, 2'd0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule